// File: doc/BRIEF.md
# Interrupt Controller Command and Initialization Decoder

This block is the register front end of one eight-line priority interrupt controller. A processor talks to it over a byte-wide bus with a single address bit: address 0 carries the initialization start word and the operation commands, address 1 carries the remaining initialization words and, once set up, the line mask. The block walks the multi-word initialization sequence. It decodes the end-of-interrupt, rotation, poll and read-select commands. It holds the mode state that the rest of the controller uses.

The request and in-service registers live in a neighbouring block and arrive here as inputs. This block only reads them back and issues one-cycle clear pulses for them. The priority resolver is also outside. During a poll read it supplies the granted line. The block does compute the highest-priority in-service line for the non-specific end-of-interrupt, and it does so relative to the current rotation base. A separate write strobe loads the trigger-mode register. That register keeps only the bits that are writable for a master or a slave, as chosen by a parameter.

Top module: `pic_cmd_decoder`

## Requirements
- R1: A write to address 0 with data bit 4 set starts initialization. In the next cycle the mask, rotation base and special-mask flag are 0, `initBusy` and `initPulse` are 1, `irrClr` equals the inverse of `levelMode`, and read select points back at the request register.
- R2: If bit 0 of the start word is 0, `nestedMode` and `autoEoi` are cleared at start. If bit 0 is 1, both keep their values until the fourth word arrives.
- R3: After a start, the first address-1 write sets `vecBase` to data AND 0xF8. The second address-1 write is consumed without touching the mask. If bit 0 of the start word was 1, a third write sets `nestedMode` from bit 4 and `autoEoi` from bit 1. `initBusy` drops after the last word.
- R4: A write to address 0 with bit 4 clear and bit 3 set is a mode command. Bit 2 arms poll. When bit 1 is set, read select takes bit 0 (1 = in-service). When bit 6 is set, `specialMask` takes bit 5. A flag whose enable bit is clear keeps its value.
- R5: For other address-0 writes, bits 7:5 are a command. Code 0 clears `rotateAutoEoi` and code 4 sets it. Code 6 sets `rotBase` to (data[2:0]+1) mod 8. Code 2 changes nothing.
- R6: Code 1 pulses `isrClr` for the in-service line of highest priority. Priority falls from `rotBase` upward, modulo 8. If no in-service bit is set, nothing is cleared. Code 5 does the same and also sets `rotBase` to (that line+1) mod 8.
- R7: Code 3 pulses `isrClr` for line data[2:0]. Code 7 pulses the same clear and sets `rotBase` to (data[2:0]+1) mod 8.
- R8: Once initialization is complete, an address-1 write loads `maskReg`. A read of address 1 returns the mask. A read of address 0 returns `isrIn` or `irrIn` according to read select. Read data is valid in the cycle after the read strobe.
- R9: A read while poll is armed returns 0x80 OR the granted line and pulses `irrClr` and `isrClr` for that line. With no grant it returns 0x07 and clears nothing. Either way poll is then disarmed.
- R10: A trigger-mode write sets `levelMode` to data AND 0xF8 for a master (IS_MASTER=1) or data AND 0xDE for a slave.
- R11: `isrClr`, `irrClr` and `initPulse` are zero in any cycle that does not follow a write or read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Register address bit |
| wrData | input | 8 | Write data (also the trigger-mode data) |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| trigWrEn | input | 1 | Trigger-mode register write strobe |
| irrIn | input | 8 | Current request register from the neighbour |
| isrIn | input | 8 | Current in-service register from the neighbour |
| grantValid | input | 1 | Resolver has a line to grant |
| grantLine | input | 3 | Line granted by the resolver |
| rdData | output | 8 | Read data, valid the cycle after rdEn |
| maskReg | output | 8 | Line mask |
| vecBase | output | 8 | Vector base (low three bits zero) |
| rotBase | output | 3 | Line with the highest priority |
| nestedMode | output | 1 | Special nested mode flag |
| autoEoi | output | 1 | Automatic end-of-interrupt flag |
| rotateAutoEoi | output | 1 | Rotate on automatic end-of-interrupt |
| specialMask | output | 1 | Special mask mode flag |
| levelMode | output | 8 | Trigger-mode register, 1 = level |
| isrClr | output | 8 | One-cycle in-service clear pulses |
| irrClr | output | 8 | One-cycle request clear pulses |
| initPulse | output | 1 | One-cycle pulse at initialization start |
| initBusy | output | 1 | Initialization sequence in progress |

## Verification
The bench sweeps every rotation base against all 256 in-service patterns for both non-specific end-of-interrupt forms. A finder that searched from line 0, or that did not wrap, would clear the wrong line or set the wrong base. It runs both lengths of the initialization sequence. A decoder that counted words badly would load the second word into the mask or leave `initBusy` stuck. A decoder that cleared the mode flags regardless of bit 0 would lose the nested and auto-EOI settings early. Poll reads are tried with and without a grant on every line, followed by a plain read. A poll flag that never disarmed would keep returning poll codes instead of the mask. The bench also sweeps every trigger-mode value, which catches a wrong writable-bit mask.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

  localparam int LINES  = 8;
  localparam int LINE_W = $clog2(LINES);
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] VEC_KEEP   = 8'hF8;
  localparam logic [BYTE_W-1:0] POLL_NONE  = 8'h07;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_BASE   = 2'd1,
    ST_WORD3  = 2'd2,
    ST_WORD4  = 2'd3
  } initState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic initStart;
    logic clrModes;
    logic baseLoad;
    logic word4Load;
    logic maskLoad;
    logic selWe;
    logic smWe;
    logic rotAutoWe;
    logic eoiHigh;
    logic rotFromHigh;
    logic eoiLine;
    logic rotFromData;
    logic pollRead;
    logic regRead;
  } cmdStrobe_t;

  function automatic logic [LINES-1:0] lineOneHot(input logic [LINE_W-1:0] line);
    return LINES'(1) << line;
  endfunction

endpackage

// File: rtl/pic_prio_find.sv
module pic_prio_find
  import pic_cmd_pkg::*;
(
  input  logic [LINES-1:0]  vec,
  input  logic [LINE_W-1:0] base,
  output logic              hit,
  output logic [LINE_W-1:0] line
);

  logic [LINE_W-1:0] idx;

  // first set bit when walking upward from base, wrapping modulo LINES
  always_comb begin
    hit  = 1'b0;
    line = '0;
    idx  = '0;
    for (int i = 0; i < LINES; i++) begin
      idx = base + LINE_W'(i);
      if (!hit && vec[idx]) begin
        hit  = 1'b1;
        line = idx;
      end
    end
  end

endmodule

// File: rtl/pic_cmd_ctrl.sv
module pic_cmd_ctrl
  import pic_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output cmdStrobe_t        stb,
  output logic              initBusy
);

  initState_t state, nextState;
  logic       needWord4;
  logic       pollArmed;
  logic       armPoll;

  always_comb begin
    stb       = '0;
    nextState = state;
    armPoll   = 1'b0;
    if (wrEn) begin
      if (!addr) begin
        if (wrData[4]) begin
          stb.initStart = 1'b1;
          stb.clrModes  = !wrData[0];
          nextState     = ST_BASE;
        end else if (wrData[3]) begin
          stb.selWe = wrData[1];
          stb.smWe  = wrData[6];
          armPoll   = wrData[2];
        end else begin
          case (wrData[7:5])
            3'd0, 3'd4: stb.rotAutoWe = 1'b1;
            3'd1:       stb.eoiHigh   = 1'b1;
            3'd5: begin
              stb.eoiHigh     = 1'b1;
              stb.rotFromHigh = 1'b1;
            end
            3'd3:       stb.eoiLine   = 1'b1;
            3'd6:       stb.rotFromData = 1'b1;
            3'd7: begin
              stb.eoiLine     = 1'b1;
              stb.rotFromData = 1'b1;
            end
            default: ;
          endcase
        end
      end else begin
        case (state)
          ST_NORMAL: stb.maskLoad = 1'b1;
          ST_BASE: begin
            stb.baseLoad = 1'b1;
            nextState    = ST_WORD3;
          end
          ST_WORD3: nextState = needWord4 ? ST_WORD4 : ST_NORMAL;
          ST_WORD4: begin
            stb.word4Load = 1'b1;
            nextState     = ST_NORMAL;
          end
          default: nextState = ST_NORMAL;
        endcase
      end
    end
    if (rdEn) begin
      stb.pollRead = pollArmed;
      stb.regRead  = !pollArmed;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_NORMAL;
      needWord4 <= 1'b0;
      pollArmed <= 1'b0;
    end else begin
      state     <= nextState;
      if (stb.initStart) needWord4 <= wrData[0];
      pollArmed <= (pollArmed && !rdEn) || armPoll;
    end
  end

  assign initBusy = (state != ST_NORMAL);

endmodule

// File: rtl/pic_cmd_dpath.sv
module pic_cmd_dpath
  import pic_cmd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] TRIG_KEEP = 8'hF8
)(
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        stb,
  input  logic              addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              trigWrEn,
  input  logic [LINES-1:0]  irrIn,
  input  logic [LINES-1:0]  isrIn,
  input  logic              grantValid,
  input  logic [LINE_W-1:0] grantLine,
  output logic [BYTE_W-1:0] rdData,
  output logic [LINES-1:0]  maskReg,
  output logic [BYTE_W-1:0] vecBase,
  output logic [LINE_W-1:0] rotBase,
  output logic              nestedMode,
  output logic              autoEoi,
  output logic              rotateAutoEoi,
  output logic              specialMask,
  output logic [LINES-1:0]  levelMode,
  output logic [LINES-1:0]  isrClr,
  output logic [LINES-1:0]  irrClr,
  output logic              initPulse
);

  logic              readIsr;
  logic              highHit;
  logic [LINE_W-1:0] highLine;
  logic [LINE_W-1:0] dataLine;

  assign dataLine = wrData[LINE_W-1:0];

  pic_prio_find u_find (
    .vec  (isrIn),
    .base (rotBase),
    .hit  (highHit),
    .line (highLine)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData        <= '0;
      maskReg       <= '0;
      vecBase       <= '0;
      rotBase       <= '0;
      nestedMode    <= 1'b0;
      autoEoi       <= 1'b0;
      rotateAutoEoi <= 1'b0;
      specialMask   <= 1'b0;
      readIsr       <= 1'b0;
      levelMode     <= '0;
      isrClr        <= '0;
      irrClr        <= '0;
      initPulse     <= 1'b0;
    end else begin
      isrClr    <= '0;
      irrClr    <= '0;
      initPulse <= 1'b0;

      if (stb.initStart) begin
        maskReg     <= '0;
        rotBase     <= '0;
        specialMask <= 1'b0;
        readIsr     <= 1'b0;
        irrClr      <= ~levelMode;
        initPulse   <= 1'b1;
        if (stb.clrModes) begin
          nestedMode <= 1'b0;
          autoEoi    <= 1'b0;
        end
      end

      if (stb.baseLoad)  vecBase <= wrData & VEC_KEEP;
      if (stb.word4Load) begin
        nestedMode <= wrData[4];
        autoEoi    <= wrData[1];
      end
      if (stb.maskLoad)  maskReg <= wrData;

      if (stb.selWe)     readIsr       <= wrData[0];
      if (stb.smWe)      specialMask   <= wrData[5];
      if (stb.rotAutoWe) rotateAutoEoi <= wrData[7];

      if (stb.eoiHigh && highHit) begin
        isrClr <= lineOneHot(highLine);
        if (stb.rotFromHigh) rotBase <= highLine + LINE_W'(1);
      end
      if (stb.eoiLine)     isrClr  <= lineOneHot(dataLine);
      if (stb.rotFromData) rotBase <= dataLine + LINE_W'(1);

      if (stb.pollRead) begin
        if (grantValid) begin
          rdData <= {1'b1, {(BYTE_W-1-LINE_W){1'b0}}, grantLine};
          isrClr <= lineOneHot(grantLine);
          irrClr <= lineOneHot(grantLine);
        end else begin
          rdData <= POLL_NONE;
        end
      end else if (stb.regRead) begin
        rdData <= addr ? maskReg : (readIsr ? isrIn : irrIn);
      end

      if (trigWrEn) levelMode <= wrData & TRIG_KEEP;
    end
  end

endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
  import pic_cmd_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              trigWrEn,
  input  logic [LINES-1:0]  irrIn,
  input  logic [LINES-1:0]  isrIn,
  input  logic              grantValid,
  input  logic [LINE_W-1:0] grantLine,
  output logic [BYTE_W-1:0] rdData,
  output logic [LINES-1:0]  maskReg,
  output logic [BYTE_W-1:0] vecBase,
  output logic [LINE_W-1:0] rotBase,
  output logic              nestedMode,
  output logic              autoEoi,
  output logic              rotateAutoEoi,
  output logic              specialMask,
  output logic [LINES-1:0]  levelMode,
  output logic [LINES-1:0]  isrClr,
  output logic [LINES-1:0]  irrClr,
  output logic              initPulse,
  output logic              initBusy
);

  // writable trigger-mode bits differ between the two controller roles
  localparam logic [BYTE_W-1:0] TRIG_KEEP = IS_MASTER ? 8'hF8 : 8'hDE;

  cmdStrobe_t stb;

  pic_cmd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .wrData   (wrData),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .stb      (stb),
    .initBusy (initBusy)
  );

  pic_cmd_dpath #(.TRIG_KEEP(TRIG_KEEP)) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .addr          (addr),
    .wrData        (wrData),
    .trigWrEn      (trigWrEn),
    .irrIn         (irrIn),
    .isrIn         (isrIn),
    .grantValid    (grantValid),
    .grantLine     (grantLine),
    .rdData        (rdData),
    .maskReg       (maskReg),
    .vecBase       (vecBase),
    .rotBase       (rotBase),
    .nestedMode    (nestedMode),
    .autoEoi       (autoEoi),
    .rotateAutoEoi (rotateAutoEoi),
    .specialMask   (specialMask),
    .levelMode     (levelMode),
    .isrClr        (isrClr),
    .irrClr        (irrClr),
    .initPulse     (initPulse)
  );

endmodule

// File: rtl/pic_cmd_checks.sv
module pic_cmd_checks #(
  parameter int LINE_W = 3
)(
  input logic       clk,
  input logic       rstN,
  input logic       addr,
  input logic [7:0] wrData,
  input logic       wrEn,
  input logic       rdEn,
  input logic       trigWrEn,
  input logic [7:0] maskReg,
  input logic [LINE_W-1:0] rotBase,
  input logic [7:0] levelMode,
  input logic [7:0] isrClr,
  input logic [7:0] irrClr,
  input logic       initPulse,
  input logic       initBusy,
  input logic [7:0] trigKeep
);

  // R1
  init_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && wrData[4]) |=> (maskReg == 8'h00 && rotBase == '0 && initBusy && initPulse));

  // R8
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr && !initBusy) |=> (maskReg == $past(wrData)));

  // R11
  quiet_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !rdEn) |=> (isrClr == 8'h00 && irrClr == 8'h00 && !initPulse));

  // R10
  trig_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigWrEn |=> (levelMode == ($past(wrData) & trigKeep)));

  // R5
  rot_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && wrData[7:3] == 5'b11000) |=>
      (rotBase == $past(wrData[LINE_W-1:0]) + LINE_W'(1)));

endmodule

bind pic_cmd_decoder pic_cmd_checks #(.LINE_W(3)) chk (
  .clk       (clk),
  .rstN      (rstN),
  .addr      (addr),
  .wrData    (wrData),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .trigWrEn  (trigWrEn),
  .maskReg   (maskReg),
  .rotBase   (rotBase),
  .levelMode (levelMode),
  .isrClr    (isrClr),
  .irrClr    (irrClr),
  .initPulse (initPulse),
  .initBusy  (initBusy),
  .trigKeep  (TRIG_KEEP)
);

// File: tb/tb_pic_cmd_decoder.sv
`timescale 1ns/1ps
module tb_pic_cmd_decoder;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic       trigWrEn = 1'b0;
  logic [7:0] irrIn = 8'h00;
  logic [7:0] isrIn = 8'h00;
  logic       grantValid = 1'b0;
  logic [2:0] grantLine = 3'd0;

  logic [7:0] rdData, maskReg, vecBase, levelMode, isrClr, irrClr;
  logic [2:0] rotBase;
  logic       nestedMode, autoEoi, rotateAutoEoi, specialMask, initPulse, initBusy;

  logic [7:0] sRdData, sMaskReg, sVecBase, sLevelMode, sIsrClr, sIrrClr;
  logic [2:0] sRotBase;
  logic       sNested, sAutoEoi, sRotAuto, sSpecMask, sInitPulse, sInitBusy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pic_cmd_decoder #(.IS_MASTER(1'b1)) dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn),
    .trigWrEn(trigWrEn), .irrIn(irrIn), .isrIn(isrIn), .grantValid(grantValid),
    .grantLine(grantLine), .rdData(rdData), .maskReg(maskReg), .vecBase(vecBase),
    .rotBase(rotBase), .nestedMode(nestedMode), .autoEoi(autoEoi),
    .rotateAutoEoi(rotateAutoEoi), .specialMask(specialMask), .levelMode(levelMode),
    .isrClr(isrClr), .irrClr(irrClr), .initPulse(initPulse), .initBusy(initBusy)
  );

  pic_cmd_decoder #(.IS_MASTER(1'b0)) dutSlave (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn),
    .trigWrEn(trigWrEn), .irrIn(irrIn), .isrIn(isrIn), .grantValid(grantValid),
    .grantLine(grantLine), .rdData(sRdData), .maskReg(sMaskReg), .vecBase(sVecBase),
    .rotBase(sRotBase), .nestedMode(sNested), .autoEoi(sAutoEoi),
    .rotateAutoEoi(sRotAuto), .specialMask(sSpecMask), .levelMode(sLevelMode),
    .isrClr(sIsrClr), .irrClr(sIrrClr), .initPulse(sInitPulse), .initBusy(sInitBusy)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic a);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic trig(input logic [7:0] d);
    @(negedge clk);
    wrData = d; trigWrEn = 1'b1;
    @(negedge clk);
    trigWrEn = 1'b0;
  endtask

  // expected highest-priority in-service line, searching upward from rot
  function automatic logic [8:0] expHigh(input logic [7:0] p, input int rot);
    for (int i = 0; i < 8; i++) begin
      int idx = (rot + i) % 8;
      if (p[idx]) return {1'b1, 8'(1 << idx)};
    end
    return 9'h000;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("reset maskReg", maskReg, 8'h00);
    chk("reset vecBase", vecBase, 8'h00);
    chk("reset rotBase", {5'b0, rotBase}, 8'h00);
    chk("reset initBusy", {7'b0, initBusy}, 8'h00);
    chk("reset rdData", rdData, 8'h00);

    // R10 trigger-mode writable bits, both roles
    for (int v = 0; v < 256; v++) begin
      trig(8'(v));
      chk("R10 master levelMode", levelMode, 8'(v) & 8'hF8);
      chk("R10 slave levelMode", sLevelMode, 8'(v) & 8'hDE);
    end
    trig(8'hA8);

    // R8 mask load and readback
    for (int v = 0; v < 256; v++) begin
      wr(1'b1, 8'(v));
      chk("R8 maskReg", maskReg, 8'(v));
      rd(1'b1);
      chk("R8 mask read", rdData, 8'(v));
    end
    irrIn = 8'h3C; isrIn = 8'hC1;
    rd(1'b0);
    chk("R8 irr read", rdData, 8'h3C);

    // R4 read select and special mask
    wr(1'b0, 8'h0B);
    rd(1'b0);
    chk("R4 select isr", rdData, 8'hC1);
    wr(1'b0, 8'h0A);
    rd(1'b0);
    chk("R4 select irr", rdData, 8'h3C);
    wr(1'b0, 8'h09);
    rd(1'b0);
    chk("R4 select ignored", rdData, 8'h3C);
    wr(1'b0, 8'h68);
    chk("R4 special mask set", {7'b0, specialMask}, 8'h01);
    wr(1'b0, 8'h28);
    chk("R4 special mask kept", {7'b0, specialMask}, 8'h01);

    // R1 / R3 initialization without fourth word
    wr(1'b1, 8'h5A);
    wr(1'b0, 8'h0B);
    wr(1'b0, 8'hC3);
    chk("R5 rot before init", {5'b0, rotBase}, 8'h04);
    wr(1'b0, 8'h10);
    chk("R1 mask cleared", maskReg, 8'h00);
    chk("R1 rot cleared", {5'b0, rotBase}, 8'h00);
    chk("R1 special mask cleared", {7'b0, specialMask}, 8'h00);
    chk("R1 initBusy", {7'b0, initBusy}, 8'h01);
    chk("R1 initPulse", {7'b0, initPulse}, 8'h01);
    chk("R1 irrClr edge lines", irrClr, 8'h57);
    wr(1'b1, 8'h5B);
    chk("R3 vecBase", vecBase, 8'h58);
    chk("R3 still busy", {7'b0, initBusy}, 8'h01);
    wr(1'b1, 8'hAA);
    chk("R3 done short", {7'b0, initBusy}, 8'h00);
    chk("R3 second word consumed", maskReg, 8'h00);
    rd(1'b0);
    chk("R1 select reset to irr", rdData, 8'h3C);

    // R3 / R2 with fourth word
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h21);
    chk("R3 vecBase long", vecBase, 8'h20);
    wr(1'b1, 8'h00);
    chk("R3 waiting word4", {7'b0, initBusy}, 8'h01);
    wr(1'b1, 8'h12);
    chk("R3 nested set", {7'b0, nestedMode}, 8'h01);
    chk("R3 autoEoi set", {7'b0, autoEoi}, 8'h01);
    chk("R3 done long", {7'b0, initBusy}, 8'h00);
    wr(1'b0, 8'h11);
    chk("R2 nested kept", {7'b0, nestedMode}, 8'h01);
    chk("R2 autoEoi kept", {7'b0, autoEoi}, 8'h01);
    wr(1'b1, 8'h08); wr(1'b1, 8'h00); wr(1'b1, 8'h02);
    chk("R3 nested from word4", {7'b0, nestedMode}, 8'h00);
    chk("R3 autoEoi from word4", {7'b0, autoEoi}, 8'h01);
    wr(1'b0, 8'h10);
    chk("R2 autoEoi cleared", {7'b0, autoEoi}, 8'h00);
    wr(1'b1, 8'h40); wr(1'b1, 8'h00);
    chk("R3 base again", vecBase, 8'h40);

    // R5 rotate-on-auto-EOI, no-op, set base
    wr(1'b0, 8'h80);
    chk("R5 rotAuto set", {7'b0, rotateAutoEoi}, 8'h01);
    wr(1'b0, 8'h00);
    chk("R5 rotAuto clear", {7'b0, rotateAutoEoi}, 8'h00);
    wr(1'b0, 8'h40);
    chk("R5 nop isrClr", isrClr, 8'h00);
    chk("R5 nop rotBase", {5'b0, rotBase}, 8'h00);
    for (int d = 0; d < 8; d++) begin
      wr(1'b0, 8'hC0 | 8'(d));
      chk("R5 rot set", {5'b0, rotBase}, 8'((d + 1) % 8));
    end

    // R6 non-specific EOI across every base and pattern
    for (int rot = 0; rot < 8; rot++) begin
      for (int p = 0; p < 256; p++) begin
        logic [8:0] e;
        isrIn = 8'(p);
        e = expHigh(8'(p), rot);
        wr(1'b0, 8'hC0 | 8'((rot + 7) % 8));
        wr(1'b0, 8'h20);
        chk("R6 eoi clear", isrClr, e[7:0]);
        wr(1'b0, 8'hA0);
        chk("R6 rotating eoi clear", isrClr, e[7:0]);
        if (e[8]) begin
          int ln = 0;
          for (int k = 0; k < 8; k++) if (e[k]) ln = k;
          chk("R6 rotating base", {5'b0, rotBase}, 8'((ln + 1) % 8));
        end else begin
          chk("R6 base kept", {5'b0, rotBase}, 8'(rot));
        end
      end
    end

    // R7 specific EOI
    wr(1'b0, 8'hC1);
    for (int l = 0; l < 8; l++) begin
      wr(1'b0, 8'h60 | 8'(l));
      chk("R7 specific clear", isrClr, 8'(1 << l));
      wr(1'b0, 8'hE0 | 8'(l));
      chk("R7 rotating specific clear", isrClr, 8'(1 << l));
      chk("R7 rotating specific base", {5'b0, rotBase}, 8'((l + 1) % 8));
    end

    // R9 poll
    wr(1'b1, 8'h96);
    for (int l = 0; l < 8; l++) begin
      grantValid = 1'b1; grantLine = 3'(l);
      wr(1'b0, 8'h0C);
      rd(1'b1);
      chk("R9 poll data", rdData, 8'h80 | 8'(l));
      chk("R9 poll irrClr", irrClr, 8'(1 << l));
      chk("R9 poll isrClr", isrClr, 8'(1 << l));
      rd(1'b1);
      chk("R9 poll disarmed", rdData, 8'h96);
    end
    grantValid = 1'b0;
    wr(1'b0, 8'h0C);
    rd(1'b0);
    chk("R9 poll none", rdData, 8'h07);
    chk("R9 none irrClr", irrClr, 8'h00);
    chk("R9 none isrClr", isrClr, 8'h00);

    // R11 quiet cycles
    @(negedge clk);
    chk("R11 isrClr idle", isrClr, 8'h00);
    chk("R11 irrClr idle", irrClr, 8'h00);
    chk("R11 initPulse idle", {7'b0, initPulse}, 8'h00);

    summary();
  end

endmodule